// File: doc/BRIEF.md
# Variable-Pattern SPI Clock Generator

This block produces the serial clock for an SPI master whose half-periods need not all be the same length. Each half-period of the serial clock lasts either a base or an alternate number of system clocks. A 32-bit rate pattern, walked from its most significant bit downward, picks which of the two applies. The choice for any half-period is read from the pattern position one step earlier. When the variable mode is off, every half-period uses the base divider.

A transfer begins with a one-cycle `start` pulse while the generator is idle and enabled. At that moment both dividers, the pattern and the mode bit are captured and held until the transfer ends. The generator then emits exactly 16 serial clock cycles. Two one-clock strobes, one per serial clock transition, let a separate shifter launch and sample data without decoding the clock itself. A one-clock `done` pulse closes the transfer. The block has no data path, so every pin is a plain control or status signal and no valid/ready handshake applies.

Top module: `varclk_sclk_gen`

## Requirements
- R1: After reset and while idle, `sclk` is low and `lead_stb`, `trail_stb` and `done` are all low.
- R2: A transfer captures `div_base`, `div_alt`, `rate_pattern` and `var_mode` in the cycle `start` is accepted; changing those inputs during the transfer has no effect on its timing.
- R3: A half-period selecting divider value d lasts 2*(d+1) system clocks; the first half-period always uses `div_base`, so the first rising edge of `sclk` comes 2*(div_base+1) clocks after the accepting edge.
- R4: With `var_mode` low, every half-period lasts 2*(div_base+1) clocks whatever `rate_pattern` holds.
- R5: With `var_mode` high, half-period k (numbered from 0, k >= 1) uses `div_alt` when `rate_pattern[32-k]` is 1 and `div_base` when it is 0; serial cycle c is therefore governed by the bit pair at positions 31-2c and 30-2c shifted one place toward the MSB, and bit 0 is never consulted.
- R6: `lead_stb` is high for exactly the one clock in which `sclk` has just risen, and `trail_stb` for exactly the one clock in which it has just fallen; at most one of `lead_stb`, `trail_stb`, `done` is high at a time.
- R7: Each transfer yields exactly 16 rising and 16 falling edges; `done` is high for one clock, the clock after the final `trail_stb`, with `sclk` low.
- R8: A `start` pulse is ignored while a transfer is running (up to and including the cycle of the final falling edge) and whenever `en` is low.
- R9: Driving `en` low aborts a transfer: from the next clock `sclk` is low, and no further strobes and no `done` appear for that transfer.
- R10: A `start` presented in the same cycle that `done` is visible is accepted, giving back-to-back transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Generator enable; low aborts and holds idle |
| start | input | 1 | One-cycle request to begin a transfer |
| var_mode | input | 1 | 1 selects per-half-period rate pattern, 0 fixed base rate |
| div_base | input | 16 | Base divider value |
| div_alt | input | 16 | Alternate divider value |
| rate_pattern | input | 32 | Divider-selection pattern, walked from bit 31 |
| sclk | output | 1 | Serial clock, idles low |
| lead_stb | output | 1 | One-clock pulse on each rising `sclk` edge |
| trail_stb | output | 1 | One-clock pulse on each falling `sclk` edge |
| done | output | 1 | One-clock pulse ending a transfer |

## Verification
The end of one transfer and the acceptance of the next can fall together: `done` is visible in the same clock where a fresh `start` is presented. The bench provokes this by computing the exact `done` cycle from the requirements and raising `start` there, then expecting the second transfer's first rising edge exactly 2*(div_base+1) clocks later with no lost or extra strobe. A second overlap, a `start` arriving mid-transfer while edges are being produced, is judged by the scoreboard seeing no event that was not predicted.

// File: rtl/vsc_pkg.sv
`timescale 1ns/1ps
package vsc_pkg;
  // Sequencing states of the serial clock generator
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } vsc_state_e;
endpackage

// File: rtl/vsc_half_timer.sv
`timescale 1ns/1ps
// Down-counter that measures one serial clock half-period.
module vsc_half_timer #(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/vsc_rate_sel.sv
`timescale 1ns/1ps
// Captures the transfer settings and computes the reload value of the
// half-period timer from the rate pattern.
module vsc_rate_sel #(
  parameter int DIV_W = 16,
  parameter int PAT_W = 32,
  parameter int IDX_W = 5,
  parameter int CNT_W = DIV_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic             var_i,
  input  logic [DIV_W-1:0] div_base_i,
  input  logic [DIV_W-1:0] div_alt_i,
  input  logic [PAT_W-1:0] pat_i,
  input  logic [IDX_W-1:0] cur_idx,
  output logic [CNT_W-1:0] first_len,
  output logic [CNT_W-1:0] next_len
);
  logic             var_q;
  logic [DIV_W-1:0] base_q;
  logic [DIV_W-1:0] alt_q;
  logic [PAT_W-1:0] pat_q;
  logic [PAT_W-1:0] pat_shift;
  logic             use_alt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      var_q  <= 1'b0;
      base_q <= '0;
      alt_q  <= '0;
      pat_q  <= '0;
    end else if (capture) begin
      var_q  <= var_i;
      base_q <= div_base_i;
      alt_q  <= div_alt_i;
      pat_q  <= pat_i;
    end
  end

  // Bit at the current walk position decides the following half-period.
  always_comb begin
    pat_shift = pat_q << cur_idx;
    use_alt   = var_q & pat_shift[PAT_W-1];
  end

  // Reload value is (length - 1) = 2*(div+1) - 1 = 2*div + 1.
  assign first_len = {div_base_i, 1'b1};
  assign next_len  = use_alt ? {alt_q, 1'b1} : {base_q, 1'b1};
endmodule

// File: rtl/vsc_edge_ctrl.sv
`timescale 1ns/1ps
// Sequencer: accepts a start, toggles the serial clock at each timer
// expiry, raises the edge strobes and closes the transfer.
module vsc_edge_ctrl
  import vsc_pkg::*;
#(
  parameter int HALVES = 32,
  parameter int IDX_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             start,
  input  logic             tmr_zero,
  output logic             accept,
  output logic             advance,
  output logic             tmr_clr,
  output logic [IDX_W-1:0] cur_idx,
  output logic             sclk,
  output logic             lead_stb,
  output logic             trail_stb,
  output logic             done
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(HALVES - 1);

  vsc_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic             sclk_q;
  logic             lead_q;
  logic             trail_q;
  logic             done_q;
  logic             edge_now;

  always_comb begin
    edge_now = (state_q == ST_RUN) && en && tmr_zero;
    accept   = (state_q == ST_IDLE) && en && start;
    advance  = edge_now && (idx_q != LAST_IDX);
    tmr_clr  = !en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      sclk_q  <= 1'b0;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
      done_q  <= 1'b0;
    end else if (!en) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      sclk_q  <= 1'b0;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
      done_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_RUN;
            idx_q   <= '0;
            sclk_q  <= 1'b0;
          end
        end
        ST_RUN: begin
          if (tmr_zero) begin
            sclk_q  <= ~sclk_q;
            lead_q  <= ~sclk_q;
            trail_q <= sclk_q;
            if (idx_q == LAST_IDX) begin
              state_q <= ST_FIN;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        ST_FIN: begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cur_idx   = idx_q;
  assign sclk      = sclk_q;
  assign lead_stb  = lead_q;
  assign trail_stb = trail_q;
  assign done      = done_q;
endmodule

// File: rtl/varclk_sclk_gen.sv
`timescale 1ns/1ps
// SPI master serial clock generator with per-half-period rate pattern.
module varclk_sclk_gen #(
  parameter int DIV_W       = 16,
  parameter int SCLK_CYCLES = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic                     start,
  input  logic                     var_mode,
  input  logic [DIV_W-1:0]         div_base,
  input  logic [DIV_W-1:0]         div_alt,
  input  logic [2*SCLK_CYCLES-1:0] rate_pattern,
  output logic                     sclk,
  output logic                     lead_stb,
  output logic                     trail_stb,
  output logic                     done
);
  localparam int HALVES = 2 * SCLK_CYCLES;
  localparam int PAT_W  = HALVES;
  localparam int IDX_W  = $clog2(HALVES);
  localparam int CNT_W  = DIV_W + 1;

  logic             accept;
  logic             advance;
  logic             tmr_clr;
  logic             tmr_zero;
  logic [IDX_W-1:0] cur_idx;
  logic [CNT_W-1:0] first_len;
  logic [CNT_W-1:0] next_len;
  logic [CNT_W-1:0] load_val;

  assign load_val = accept ? first_len : next_len;

  vsc_rate_sel #(
    .DIV_W (DIV_W),
    .PAT_W (PAT_W),
    .IDX_W (IDX_W),
    .CNT_W (CNT_W)
  ) u_rate (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture    (accept),
    .var_i      (var_mode),
    .div_base_i (div_base),
    .div_alt_i  (div_alt),
    .pat_i      (rate_pattern),
    .cur_idx    (cur_idx),
    .first_len  (first_len),
    .next_len   (next_len)
  );

  vsc_half_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (tmr_clr),
    .load     (accept | advance),
    .load_val (load_val),
    .zero     (tmr_zero)
  );

  vsc_edge_ctrl #(
    .HALVES (HALVES),
    .IDX_W  (IDX_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .start     (start),
    .tmr_zero  (tmr_zero),
    .accept    (accept),
    .advance   (advance),
    .tmr_clr   (tmr_clr),
    .cur_idx   (cur_idx),
    .sclk      (sclk),
    .lead_stb  (lead_stb),
    .trail_stb (trail_stb),
    .done      (done)
  );
endmodule

// File: rtl/vsc_checker.sv
`timescale 1ns/1ps
// Temporal checks on the generator ports.
module vsc_checker (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic sclk,
  input logic lead_stb,
  input logic trail_stb,
  input logic done
);
  // R6
  lead_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lead_stb |-> $rose(sclk));

  // R6
  trail_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trail_stb |-> $fell(sclk));

  // R6
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lead_stb, trail_stb, done}));

  // R7
  done_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trail_stb |=> (!sclk && !lead_stb));

  // R9
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!sclk && !lead_stb && !trail_stb && !done));

  // R3
  min_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lead_stb || trail_stb) |=> $stable(sclk));
endmodule

bind varclk_sclk_gen vsc_checker u_vsc_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .sclk      (sclk),
  .lead_stb  (lead_stb),
  .trail_stb (trail_stb),
  .done      (done)
);

// File: tb/tb_varclk_sclk_gen.sv
`timescale 1ns/1ps
module tb_varclk_sclk_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        start = 1'b0;
  logic        var_mode = 1'b0;
  logic [15:0] div_base = '0;
  logic [15:0] div_alt = '0;
  logic [31:0] rate_pattern = '0;
  logic        sclk, lead_stb, trail_stb, done;

  varclk_sclk_gen dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (en),
    .start        (start),
    .var_mode     (var_mode),
    .div_base     (div_base),
    .div_alt      (div_alt),
    .rate_pattern (rate_pattern),
    .sclk         (sclk),
    .lead_stb     (lead_stb),
    .trail_stb    (trail_stb),
    .done         (done)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    at;
    int    kind;   // 0 rising, 1 falling, 2 done
    string req;
  } ev_t;

  ev_t exp_q[$];
  int  checks = 0;
  int  errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Monitor: pops predicted events and compares them with observed ones.
  always @(negedge clk) begin
    if (rst_n && (lead_stb || trail_stb || done)) begin
      int kind;
      kind = lead_stb ? 0 : (trail_stb ? 1 : 2);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8", "unpredicted event kind", kind, -1);
      end else begin
        ev_t e;
        e = exp_q.pop_front();
        chk(e.at == cyc, e.req, "event cycle", cyc, e.at);
        chk(e.kind == kind, "R6", "event kind", kind, e.kind);
        if (kind == 2) chk(sclk == 1'b0, "R7", "sclk at done", int'(sclk), 0);
        else chk(int'(sclk) == (kind == 0 ? 1 : 0), "R6", "sclk level at strobe",
                 int'(sclk), (kind == 0 ? 1 : 0));
      end
    end
  end

  // Half-period length from the requirements (R3, R4, R5).
  function automatic int half_len(input int k, input logic [15:0] a,
                                  input logic [15:0] b, input logic [31:0] p,
                                  input bit vm);
    if (k == 0 || !vm || !p[32-k]) return 2 * (int'(a) + 1);
    return 2 * (int'(b) + 1);
  endfunction

  // Driver: called at a negedge; presents start and pushes predictions.
  task automatic launch(input logic [15:0] a, input logic [15:0] b,
                        input logic [31:0] p, input bit vm, input int stop_rel,
                        output int acc, output int end_cyc);
    int t;
    div_base = a; div_alt = b; rate_pattern = p; var_mode = vm;
    start = 1'b1;
    acc = cyc + 1;
    t = acc;
    for (int k = 0; k < 32; k++) begin
      t += half_len(k, a, b, p, vm);
      if (t < acc + stop_rel)
        exp_q.push_back('{t, k % 2, (k == 0) ? "R3" : (vm ? "R5" : "R4")});
    end
    end_cyc = t;
    if (t + 1 < acc + stop_rel) exp_q.push_back('{t + 1, 2, "R7"});
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic drain(input string req);
    int n = 0;
    while (exp_q.size() != 0 && n < 5000) begin
      @(negedge clk);
      n++;
    end
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, req, "pending predictions", exp_q.size(), 0);
  endtask

  localparam int NOSTOP = 1000000;

  initial begin
    #(5.0 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    int acc, e1, e2;
    repeat (5) @(negedge clk);
    // R1: reset state
    chk(sclk == 1'b0, "R1", "sclk in reset", int'(sclk), 0);
    chk(lead_stb == 1'b0 && trail_stb == 1'b0, "R1", "strobes in reset",
        int'({lead_stb, trail_stb}), 0);
    chk(done == 1'b0, "R1", "done in reset", int'(done), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    chk(sclk == 1'b0, "R1", "sclk idle", int'(sclk), 0);

    // R4 fixed rate, pattern ignored; R2 inputs changed mid-transfer; R8 stray start
    launch(16'd1, 16'd3, 32'hF0F0_FFFF, 1'b0, NOSTOP, acc, e1);
    div_base = 16'd9; div_alt = 16'd0; rate_pattern = 32'h0; var_mode = 1'b1;
    repeat (20) @(negedge clk);
    start = 1'b1;            // R8: ignored while running
    @(negedge clk);
    start = 1'b0;
    drain("R2");

    // R5 mixed pattern: ten base halves, then alternate, then back
    @(negedge clk);
    launch(16'd1, 16'd2, 32'h007F_FF87, 1'b1, NOSTOP, acc, e1);
    drain("R5");

    // R5 all ones: first half base, rest alternate
    @(negedge clk);
    launch(16'd0, 16'd4, 32'hFFFF_FFFF, 1'b1, NOSTOP, acc, e1);
    drain("R5");

    // R5 alternating bits, minimal divider
    @(negedge clk);
    launch(16'd0, 16'd1, 32'hAAAA_AAAA, 1'b1, NOSTOP, acc, e1);
    drain("R3");

    // R10: start presented in the cycle done is visible
    @(negedge clk);
    launch(16'd2, 16'd0, 32'h0F0F_0F0F, 1'b1, NOSTOP, acc, e1);
    while (cyc < e1 + 1) @(negedge clk);
    chk(done == 1'b1, "R10", "done visible at relaunch", int'(done), 1);
    launch(16'd1, 16'd5, 32'h3333_CCCC, 1'b1, NOSTOP, acc, e2);
    chk(acc == e1 + 2, "R10", "accept cycle", acc, e1 + 2);
    drain("R10");

    // R8: start with en low is ignored
    en = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    en = 1'b1;
    repeat (60) @(negedge clk);
    chk(sclk == 1'b0, "R8", "sclk after start with en low", int'(sclk), 0);
    chk(exp_q.size() == 0, "R8", "pending predictions", exp_q.size(), 0);

    // R9: abort mid-transfer (edges at +8 and +16, en low sampled at +21)
    @(negedge clk);
    launch(16'd3, 16'd3, 32'h0, 1'b0, 21, acc, e1);
    while (cyc < acc + 20) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(sclk == 1'b0, "R9", "sclk after abort", int'(sclk), 0);
    repeat (300) @(negedge clk);
    chk(exp_q.size() == 0, "R9", "pending predictions", exp_q.size(), 0);
    en = 1'b1;

    // R3 after abort: a fresh transfer starts cleanly
    @(negedge clk);
    launch(16'd2, 16'd1, 32'h5555_0000, 1'b1, NOSTOP, acc, e1);
    drain("R3");

    finish_run();
  end
endmodule